// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the bit timing of an asynchronous serial port from the system clock. A prescale stage produces enable pulses and feeds a 13-bit down-counter. Each time that counter passes zero it raises a one-clock 16x oversampling tick. Every sixteenth such tick also raises the one-per-bit tick. The prescale stage has two variants, chosen at run time:

- A fixed integer divider by 2 or by 3.
- A 9-bit phase accumulator. It adds a programmable step on every clock and fires on each carry, so its enable rate is step/512 of the clock.

Software programs the block through a plain write port: a select, a data word and a write strobe. A write takes effect on the next rising clock edge. The block has no data stream, so it has no handshake. Clearing the run bit holds every counter in its start state. The reload register can only be changed while the generator is stopped.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `tick16` and `tick_bit` are low, and the run, fractional-select and divide-by-3 bits are all 0.
- R2: A write with `wr_sel`=0 loads the control bits: `wr_data[0]` is run, `wr_data[1]` selects the fractional path and `wr_data[2]` selects divide-by-3. A write with `wr_sel`=1 loads the reload value from `wr_data[12:0]`. A write with `wr_sel`=2 loads the fractional step from `wr_data[8:0]`. Select 3 is ignored.
- R3: With the fractional path off, the prescaler emits its j-th enable pulse in cycle j·P after the run bit is set. P is 2, or 3 when divide-by-3 is set. The 16x tick period is therefore P·(reload+1) clocks.
- R4: With the fractional path on, the accumulator starts at 0. The j-th enable pulse falls in cycle ceil(j·512/step) after the run bit is set, which gives an average rate of step/512 per clock.
- R5: The reload counter starts from the reload value. It counts down once per enable pulse. On the enable pulse that finds it at 0 it reloads, and `tick16` is high for exactly the next cycle. The m-th `tick16` therefore appears in cycle c+1, where c is the cycle of enable pulse m·(reload+1). Cycle 1 is the first cycle after the edge that sets run.
- R6: `tick_bit` is high only together with `tick16`, on the 16th, 32nd and every later sixteenth `tick16` counted since run was last set.
- R7: A reload write while run is 1 is ignored. The running timing and the value used after a restart both keep the previous reload value.
- R8: While run is 0, `tick16` and `tick_bit` stay low, and the prescaler, accumulator, reload counter and oversample counter are held at their start values. A restart therefore reproduces the timing of R3 to R5 exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 reload, 2 fractional step |
| wr_data | input | 13 | Write data |
| tick16 | output | 1 | One-clock 16x oversampling tick |
| tick_bit | output | 1 | One-clock tick per serial bit |

## Verification
The assertions assume that a reload write is meant to be blocked only while run is high. They also assume that the run bit comes only from control writes. The pulse-spacing property relies on the 16-tick oversample counter, which holds whatever the reload or step value. The stimulus follows the intended programming order in every case: reload and step are written while the generator is stopped, and then run is set. The single exception is a deliberate reload write during a run, which checks R7. Mode bits never change while the generator is running.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_STEP   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic pre_hi;
    logic frac_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int RELOAD_W = 13,
  parameter int FRAC_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [RELOAD_W-1:0] wr_data,
  output ctrl_t               ctrl,
  output logic [RELOAD_W-1:0] reload,
  output logic [FRAC_W-1:0]   step
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
      step   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL:   ctrl <= ctrl_t'(wr_data[2:0]);
        SEL_RELOAD: if (!ctrl.run) reload <= wr_data;
        SEL_STEP:   step <= wr_data[FRAC_W-1:0];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/fbg_prescale.sv
module fbg_prescale #(
  parameter int FRAC_W = 9,
  parameter int PRE_LO = 2,
  parameter int PRE_HI = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              frac_en,
  input  logic              pre_hi,
  input  logic [FRAC_W-1:0] step,
  output logic              en_pulse
);
  localparam int PCNT_W = $clog2(PRE_HI + 1);

  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] limit;
  logic              fixed_hit;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic              carry;

  assign limit     = pre_hi ? PCNT_W'(PRE_HI - 1) : PCNT_W'(PRE_LO - 1);
  assign fixed_hit = (pcnt == limit);
  assign sum       = {1'b0, acc} + {1'b0, step};
  assign carry     = sum[FRAC_W];
  assign en_pulse  = run & (frac_en ? carry : fixed_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (!run || frac_en) begin
      pcnt <= '0;
    end else begin
      pcnt <= fixed_hit ? '0 : pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (!run || !frac_en) begin
      acc <= '0;
    end else begin
      acc <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/fbg_reload_cnt.sv
module fbg_reload_cnt #(
  parameter int RELOAD_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                en_pulse,
  input  logic [RELOAD_W-1:0] reload,
  output logic                tick16
);
  logic [RELOAD_W-1:0] cnt;
  logic                at_zero;

  assign at_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      tick16 <= 1'b0;
    end else if (!run) begin
      cnt    <= reload;
      tick16 <= 1'b0;
    end else begin
      tick16 <= en_pulse & at_zero;
      if (en_pulse) cnt <= at_zero ? reload : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fbg_oversample.sv
module fbg_oversample #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick16,
  output logic tick_bit
);
  localparam int OS_W = $clog2(OVERSAMPLE);

  logic [OS_W-1:0] os;

  assign tick_bit = tick16 & (os == OS_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os <= '0;
    end else if (!run) begin
      os <= '0;
    end else if (tick16) begin
      os <= tick_bit ? '0 : os + 1'b1;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int RELOAD_W   = 13,
  parameter int FRAC_W     = 9,
  parameter int PRE_LO     = 2,
  parameter int PRE_HI     = 3,
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [RELOAD_W-1:0] wr_data,
  output logic                tick16,
  output logic                tick_bit
);
  ctrl_t               ctrl_q;
  logic [RELOAD_W-1:0] reload_q;
  logic [FRAC_W-1:0]   step_q;
  logic                run_q;
  logic                en_pulse;

  assign run_q = ctrl_q.run;

  fbg_regs #(.RELOAD_W(RELOAD_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl(ctrl_q), .reload(reload_q), .step(step_q)
  );

  fbg_prescale #(.FRAC_W(FRAC_W), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .frac_en(ctrl_q.frac_en),
    .pre_hi(ctrl_q.pre_hi), .step(step_q), .en_pulse(en_pulse)
  );

  fbg_reload_cnt #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .en_pulse(en_pulse),
    .reload(reload_q), .tick16(tick16)
  );

  fbg_oversample #(.OVERSAMPLE(OVERSAMPLE)) u_os (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick16(tick16),
    .tick_bit(tick_bit)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int RELOAD_W = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          wr_sel,
  input logic                run,
  input logic [RELOAD_W-1:0] reload,
  input logic                tick16,
  input logic                tick_bit
);
  a_r6_bit_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_bit |-> tick16);

  a_r6_bit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_bit |=> !tick_bit);

  a_r8_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick16);

  a_r7_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && run) |=> $stable(reload));
endmodule

bind frac_baud_gen fbg_checker #(.RELOAD_W(RELOAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .run(run_q), .reload(reload_q), .tick16(tick16), .tick_bit(tick_bit)
);

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [12:0] wr_data = '0;
  logic        tick16;
  logic        tick_bit;
  int          checks = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick16(tick16), .tick_bit(tick_bit)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Drive at a negedge; returns at the negedge after the capturing edge.
  task automatic wr(input logic [1:0] sel, input logic [12:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic longint exp_cycle(int m, int rl, bit frac, bit ph, int st);
    longint j;
    j = longint'(m) * (rl + 1);
    if (frac) return (j * 512 + st - 1) / st + 1;
    return j * (ph ? 3 : 2) + 1;
  endfunction

  task automatic idle_quiet(input int n, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick16 || tick_bit) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  // Program reload/step while stopped, set run, watch nt ticks, then stop.
  task automatic run_case(input bit ph, input bit frac, input int st, input int rl,
                          input int nt, input bit poke, input int quiet);
    int     m;
    longint c;
    longint lim;
    string  tag;
    tag = frac ? "R4" : "R3";
    wr(2'd1, 13'(rl));
    wr(2'd2, 13'(st));
    wr(2'd0, {10'd0, ph, frac, 1'b1});
    m = 0;
    c = 1;
    lim = exp_cycle(nt, rl, frac, ph, st) + 2;
    while (m < nt && c <= lim) begin
      if (tick16) begin
        m++;
        chk(c == exp_cycle(m, rl, frac, ph, st), poke ? "R7" : tag,
            c, exp_cycle(m, rl, frac, ph, st));
        chk(tick_bit == ((m % 16) == 0), "R6", tick_bit, (m % 16) == 0);
      end else if (tick_bit) begin
        chk(1'b0, "R6", 1, 0);
      end
      if (poke && c == 2) begin
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 13'(rl + 5);
      end
      if (poke && c == 3) wr_en = 1'b0;
      @(negedge clk);
      c++;
    end
    wr_en = 1'b0;
    chk(m == nt, "R5", m, nt);
    wr(2'd0, {10'd0, ph, frac, 1'b0});
    if (quiet > 0) idle_quiet(quiet, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tick16 == 1'b0, "R1", tick16, 0);
    chk(tick_bit == 1'b0, "R1", tick_bit, 0);
    rst_n = 1'b1;
    // R1/R8: stopped after reset, no ticks
    idle_quiet(30, "R1");
    // R2: select 3 writes nothing; generator stays stopped
    wr(2'd3, 13'h1fff);
    idle_quiet(20, "R2");
    // R3: fixed path sweep, both prescale constants
    for (int ph = 0; ph < 2; ph++)
      for (int rl = 0; rl < 16; rl++)
        run_case(ph[0], 1'b0, 1, rl, 3, 1'b0, 4);
    // R6: bit tick on every sixteenth oversample tick
    run_case(1'b0, 1'b0, 1, 0, 34, 1'b0, 40);
    // R4: fractional path, every step value
    for (int rl = 0; rl < 3; rl += 2)
      for (int st = 1; st < 512; st++)
        run_case(1'b0, 1'b1, st, rl, 2, 1'b0, 2);
    // R7: reload write during run is ignored
    run_case(1'b1, 1'b0, 1, 3, 4, 1'b1, 10);
    run_case(1'b0, 1'b1, 100, 1, 4, 1'b1, 10);
    // R8: restart reproduces the first-tick timing
    run_case(1'b1, 1'b0, 1, 2, 2, 1'b0, 30);
    run_case(1'b1, 1'b0, 1, 2, 2, 1'b0, 30);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule